// File: doc/BRIEF.md
# Serial EEPROM Boot Image Loader with Read-Back Verification

At start-up this block copies a boot image from an external serial EEPROM into the chip's internal memory and register space. The destination address of each byte is the same as its EEPROM address. It then checks the copy in a second pass. That pass reads the EEPROM again from address zero and, in lockstep, reads back the internal byte at the same address. The two bytes are compared one at a time. While the bytes are being loaded, an 8-bit running sum is kept. The image is laid out so that the sum of all its bytes is zero, because the last byte holds the two's complement of the sum of the others.

EEPROM bytes come from a neighbouring SPI byte engine through a request/acknowledge handshake. Internal memory is reached through a byte port with a one-cycle read latency. A failure has one of two causes. A read-back mismatch records the failing address in a low-byte register and a high-byte register. A bad checksum sets a separate flag. Either error raises the interrupt line, which has no mask, and parks the block in a safe state that only reset can clear.

States: `ST_IDLE` (waiting for start), `ST_LOAD` (fetch a byte and write it), `ST_CMP_RD` (fetch the EEPROM byte again and issue the memory read), `ST_CMP_CHK` (compare the two bytes), `ST_DONE` (image accepted), `ST_SAFE` (locked after an error). Transitions:
- IDLE→LOAD and DONE→LOAD on `start`.
- LOAD→CMP_RD on the acknowledge for the last byte.
- CMP_RD→CMP_CHK on each acknowledge.
- CMP_CHK→CMP_RD when the bytes match and the address is not the last.
- CMP_CHK→DONE when the last byte matches and the sum is zero.
- CMP_CHK→SAFE on a mismatch, or when the last byte matches but the sum is non-zero.

Top module: `eeload_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `safe`, `irq`, `cmp_err`, `sum_err`, `rd_req`, `mem_we` and `mem_re` are 0, and both fail-address bytes are 0x00.
- R2: After `start`, EEPROM addresses 0 to IMG_LEN-1 are requested in ascending order. Each acknowledged byte is written exactly once, with `mem_we` high in the acknowledge cycle and `mem_addr` equal to the source address.
- R3: The verify pass requests EEPROM addresses again from 0 upward. In each acknowledge cycle it pulses `mem_re` with `mem_addr` equal to that address, and the memory data is taken on the following cycle.
- R4: On the first mismatch between the EEPROM byte and the internal byte, `cmp_err` is set. `fail_lo` receives address bits 7:0 and `fail_hi` receives bits 15:8, and both stay unchanged afterwards. No further EEPROM request is made.
- R5: If every byte matches but the 8-bit sum of all IMG_LEN image bytes is not 0x00, `sum_err` is set after the last compare. The fail-address bytes stay 0x00.
- R6: If the image has both a mismatch and a bad sum, only `cmp_err` is reported, and `cmp_err` and `sum_err` are never high together.
- R7: A clean image ends with `done` high and `busy` low, with no error. A new `start` while done reruns the whole load and verify.
- R8: Once either error is set, `safe` stays high and `start` has no effect (no request and no `busy`) until reset.
- R9: `irq` is high whenever either error flag is high. There is no mask.
- R10: While `rd_req` is high and `rd_ack` is low, `rd_req` stays high and `rd_addr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin load and verify |
| busy | output | 1 | Load or verify in progress |
| done | output | 1 | Image loaded and verified |
| safe | output | 1 | Locked after an error |
| irq | output | 1 | Unmaskable error interrupt |
| cmp_err | output | 1 | Read-back mismatch found |
| sum_err | output | 1 | Image sum not zero |
| fail_lo | output | 8 | Mismatch address bits 7:0 |
| fail_hi | output | 8 | Mismatch address bits 15:8 |
| rd_req | output | 1 | Byte request to SPI engine |
| rd_addr | output | AW | EEPROM byte address |
| rd_ack | input | 1 | SPI engine byte ready |
| rd_data | input | 8 | EEPROM byte |
| mem_we | output | 1 | Internal memory write strobe |
| mem_re | output | 1 | Internal memory read strobe |
| mem_addr | output | AW | Internal memory address |
| mem_wdata | output | 8 | Internal write byte |
| mem_rdata | input | 8 | Internal read byte, one cycle after `mem_re` |

## Verification
The bench's memory model can hold a stuck bit at a chosen address. It places that fault at address 0, at an address above 255 and at the last address. A design that drops the high byte, captures the wrong address, or is off by one at the end of the image would record the wrong fail address. A corrupted sum is tried alone and together with a fault, so a design that checks the sum first, or keeps comparing after the first mismatch, would raise the wrong flag or keep issuing requests. The bench also pulses `start` while the block is in the safe state and again after a clean finish, which separates a lock that holds from one that can be re-entered.

// File: rtl/eeload_pkg.sv
package eeload_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_CMP_RD,
        ST_CMP_CHK,
        ST_DONE,
        ST_SAFE
    } eeload_state_t;
endpackage

// File: rtl/eeload_cksum.sv
// 8-bit modular accumulator; zero total marks a valid image.
module eeload_cksum #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          add_en,
    input  logic [DW-1:0] din,
    output logic          sum_ok
);
    logic [DW-1:0] acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      acc <= '0;
        else if (clr)    acc <= '0;
        else if (add_en) acc <= acc + din;
    end

    assign sum_ok = (acc == '0);
endmodule

// File: rtl/eeload_failcap.sv
// Holds the mismatch address, split into two byte registers.
module eeload_failcap #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic [AW-1:0] addr,
    output logic [7:0]    lo,
    output logic [7:0]    hi
);
    localparam int PW = 16;
    logic [PW-1:0] ext;

    assign ext = PW'(addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo <= '0;
            hi <= '0;
        end else if (cap) begin
            lo <= ext[7:0];
            hi <= ext[15:8];
        end
    end
endmodule

// File: rtl/eeload_ctrl.sv
module eeload_ctrl
    import eeload_pkg::*;
#(
    parameter int IMG_LEN = 300,
    parameter int AW      = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          safe,
    output logic          irq,
    output logic          cmp_err,
    output logic          sum_err,
    output logic [7:0]    fail_lo,
    output logic [7:0]    fail_hi,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [7:0]    rd_data,
    output logic          mem_we,
    output logic          mem_re,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata
);
    localparam logic [AW-1:0] LAST_A = AW'(IMG_LEN - 1);

    eeload_state_t state, nxt;
    logic [AW-1:0] addr;
    logic [7:0]    ee_byte;
    logic          is_last, go, mismatch, sum_ok, sum_bad, load_ack;

    assign is_last  = (addr == LAST_A);
    assign go       = start && (state == ST_IDLE || state == ST_DONE);
    assign load_ack = (state == ST_LOAD) && rd_ack;
    assign mismatch = (state == ST_CMP_CHK) && (mem_rdata != ee_byte);
    assign sum_bad  = (state == ST_CMP_CHK) && !mismatch && is_last && !sum_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start) nxt = ST_LOAD;
            ST_LOAD:    if (rd_ack && is_last) nxt = ST_CMP_RD;
            ST_CMP_RD:  if (rd_ack) nxt = ST_CMP_CHK;
            ST_CMP_CHK: begin
                if (mismatch)     nxt = ST_SAFE;
                else if (is_last) nxt = sum_ok ? ST_DONE : ST_SAFE;
                else              nxt = ST_CMP_RD;
            end
            ST_DONE:    if (start) nxt = ST_LOAD;
            ST_SAFE:    nxt = ST_SAFE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr    <= '0;
            ee_byte <= '0;
            cmp_err <= 1'b0;
            sum_err <= 1'b0;
        end else begin
            if (go)
                addr <= '0;
            else if (load_ack)
                addr <= is_last ? '0 : addr + 1'b1;
            else if (state == ST_CMP_CHK && !mismatch && !is_last)
                addr <= addr + 1'b1;
            if (state == ST_CMP_RD && rd_ack) ee_byte <= rd_data;
            if (mismatch) cmp_err <= 1'b1;
            if (sum_bad)  sum_err <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        rd_req    = (state == ST_LOAD) || (state == ST_CMP_RD);
        rd_addr   = addr;
        mem_we    = load_ack;
        mem_wdata = rd_data;
        mem_re    = (state == ST_CMP_RD) && rd_ack;
        mem_addr  = addr;
        busy      = (state == ST_LOAD) || (state == ST_CMP_RD) || (state == ST_CMP_CHK);
        done      = (state == ST_DONE);
        safe      = (state == ST_SAFE);
        irq       = cmp_err || sum_err;
    end

    eeload_cksum #(.DW(8)) cksum_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (go),
        .add_en (load_ack),
        .din    (rd_data),
        .sum_ok (sum_ok)
    );

    eeload_failcap #(.AW(AW)) failcap_i (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (mismatch),
        .addr  (addr),
        .lo    (fail_lo),
        .hi    (fail_hi)
    );
endmodule

// File: rtl/eeload_ctrl_chk.sv
module eeload_ctrl_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          safe,
    input logic          irq,
    input logic          cmp_err,
    input logic          sum_err,
    input logic [7:0]    fail_lo,
    input logic [7:0]    fail_hi,
    input logic          rd_req,
    input logic [AW-1:0] rd_addr,
    input logic          rd_ack,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr
);
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    assert_write_on_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (rd_req && rd_ack && mem_addr == rd_addr));

    assert_cmp_locks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_err |-> (safe && !rd_req && !busy));

    assert_fail_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        safe |=> ($stable(fail_lo) && $stable(fail_hi)));

    assert_one_error_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmp_err && sum_err));

    assert_done_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!cmp_err && !sum_err && !busy && !irq));

    assert_safe_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        safe |=> safe);

    assert_irq_unmasked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_err || sum_err) |-> (irq && safe));
endmodule

bind eeload_ctrl eeload_ctrl_chk #(.AW(AW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .safe     (safe),
    .irq      (irq),
    .cmp_err  (cmp_err),
    .sum_err  (sum_err),
    .fail_lo  (fail_lo),
    .fail_hi  (fail_hi),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .rd_ack   (rd_ack),
    .mem_we   (mem_we),
    .mem_addr (mem_addr)
);

// File: tb/eeload_ctrl_tb_top.sv
`timescale 1ns/1ps
module eeload_ctrl_tb_top;
    localparam int N  = 300;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          busy, done, safe, irq, cmp_err, sum_err;
    logic [7:0]    fail_lo, fail_hi;
    logic          rd_req, rd_ack;
    logic [AW-1:0] rd_addr, mem_addr;
    logic [7:0]    rd_data, mem_wdata, mem_rdata;
    logic          mem_we, mem_re;

    logic [7:0] img [N];
    logic [7:0] mem [N];
    int  bad_addr = -1;
    int  lat_addr, lat_cnt;
    bit  pend;
    int  wr_idx, rd_idx, order_err, req_err;
    int  nchk = 0, nfail = 0;

    always #5 clk = ~clk;

    eeload_ctrl #(.IMG_LEN(N), .AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .safe(safe), .irq(irq), .cmp_err(cmp_err), .sum_err(sum_err),
        .fail_lo(fail_lo), .fail_hi(fail_hi), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_data(rd_data), .mem_we(mem_we), .mem_re(mem_re),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // SPI byte engine and internal memory models
    initial begin
        rd_ack = 1'b0; rd_data = '0; mem_rdata = '0; pend = 1'b0; lat_cnt = 0; lat_addr = 0;
        forever begin
            @(posedge clk);
            if (mem_we && int'(mem_addr) < N)
                mem[mem_addr] <= (int'(mem_addr) == bad_addr) ? (mem_wdata ^ 8'h10) : mem_wdata;
            if (mem_re && int'(mem_addr) < N)
                mem_rdata <= mem[mem_addr];
            if (!rst_n) begin
                rd_ack <= 1'b0; pend <= 1'b0;
            end else if (rd_ack) begin
                rd_ack <= 1'b0;
            end else if (pend) begin
                if (lat_cnt == 0) begin
                    rd_ack <= 1'b1; rd_data <= img[lat_addr]; pend <= 1'b0;
                end else lat_cnt <= lat_cnt - 1;
            end else if (rd_req) begin
                pend <= 1'b1; lat_addr <= int'(rd_addr); lat_cnt <= 2;
            end
        end
    end

    // ordering monitor (R2, R3, R10)
    initial forever begin
        @(negedge clk);
        if (rst_n && rd_ack && int'(rd_addr) != lat_addr) req_err++;
        if (rst_n && mem_we) begin
            if (int'(mem_addr) != wr_idx) order_err++;
            wr_idx++;
        end
        if (rst_n && mem_re) begin
            if (int'(mem_addr) != rd_idx) order_err++;
            rd_idx++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic build(input bit bad_sum, input int fault);
        logic [7:0] s = '0;
        for (int i = 0; i < N - 1; i++) begin
            img[i] = 8'((i * 7 + 3) & 255);
            s = s + img[i];
        end
        img[N-1] = 8'(-s);
        if (bad_sum) img[N-1] = img[N-1] + 8'd1;
        bad_addr = fault;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run(output bit ended);
        wr_idx = 0; rd_idx = 0; order_err = 0; req_err = 0;
        start = 1'b1; @(negedge clk); start = 1'b0;
        ended = 1'b0;
        for (int c = 0; c < 20000 && !ended; c++) begin
            @(negedge clk);
            if (done || safe) ended = 1'b1;
        end
        chk(ended, "watchdog", 0, 1);
    endtask

    task automatic t_reset();
        build(1'b0, -1);
        do_reset();
        chk(!busy && !done && !safe && !irq, "R1 status", {busy, done, safe, irq}, 0);
        chk(!cmp_err && !sum_err && !rd_req && !mem_we && !mem_re, "R1 strobes",
            {cmp_err, sum_err, rd_req, mem_we, mem_re}, 0);
        chk(fail_lo == 0 && fail_hi == 0, "R1 fail addr", {fail_hi, fail_lo}, 0);
    endtask

    task automatic t_good();
        bit e; int bad = 0;
        run(e);
        chk(done && !busy && !safe, "R7 done", {done, busy, safe}, 3'b100);
        chk(!cmp_err && !sum_err && !irq, "R7 no error", {cmp_err, sum_err, irq}, 0);
        for (int i = 0; i < N; i++) if (mem[i] != img[i]) bad++;
        chk(bad == 0, "R2 memory copy", bad, 0);
        chk(wr_idx == N && order_err == 0, "R2 write order", wr_idx, N);
        chk(rd_idx == N, "R3 verify reads", rd_idx, N);
        chk(req_err == 0, "R10 address held", req_err, 0);
        // rerun from done
        start = 1'b1; @(negedge clk); start = 1'b0;
        chk(busy && !done, "R7 restart", {busy, done}, 2'b10);
        wr_idx = 0; rd_idx = 0;
        for (int c = 0; c < 20000 && !done; c++) @(negedge clk);
        chk(done && wr_idx == N && rd_idx == N, "R7 second run", wr_idx, N);
    endtask

    task automatic t_fault(input int fa, input bit bad_sum, input string tag);
        bit e; int hold = 0;
        build(bad_sum, fa);
        do_reset();
        run(e);
        chk(cmp_err && !sum_err, {tag, " cmp flag"}, {cmp_err, sum_err}, 2'b10);
        chk({fail_hi, fail_lo} == 16'(fa), {tag, " fail addr"}, {fail_hi, fail_lo}, fa);
        chk(safe && irq && !done, "R9 irq and safe", {safe, irq, done}, 3'b110);
        chk(rd_idx == fa + 1, "R3 reads up to fault", rd_idx, fa + 1);
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (rd_req) hold++;
        end
        chk(hold == 0, "R4 no further request", hold, 0);
    endtask

    task automatic t_sum();
        bit e;
        build(1'b1, -1);
        do_reset();
        run(e);
        chk(sum_err && !cmp_err, "R5 sum flag", {cmp_err, sum_err}, 2'b01);
        chk(fail_lo == 0 && fail_hi == 0, "R5 fail addr untouched", {fail_hi, fail_lo}, 0);
        chk(rd_idx == N, "R5 full compare first", rd_idx, N);
        chk(safe && irq, "R9 irq on sum", {safe, irq}, 2'b11);
    endtask

    task automatic t_locked();
        int act = 0;
        start = 1'b1; @(negedge clk); start = 1'b0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (rd_req || busy || !safe) act++;
        end
        chk(act == 0, "R8 start ignored in safe", act, 0);
        chk(sum_err && irq, "R8 error retained", {sum_err, irq}, 2'b11);
    endtask

    initial begin
        t_reset();
        t_good();
        t_fault(261, 1'b0, "R4 high byte");
        t_fault(0, 1'b0, "R4 first");
        t_fault(N - 1, 1'b0, "R4 last");
        t_fault(40, 1'b1, "R6 both");
        t_sum();
        t_locked();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #3000000;
        nchk++; nfail++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule